// File: doc/BRIEF.md
# Virtualisation-Aware Trap Router and Return Unit

This unit sits beside the privilege state of a processor that supports a guest (virtualised) supervisor level. When the pipeline reports a trap, the unit decides whether the guest supervisor, the host supervisor or the machine level handles it. It then produces the handler address and, on the same clock edge, updates the privilege mode, the virtualisation flag and the per-level status and capture registers. It also runs the machine-return and supervisor-return operations. For each of these it restores mode and virtualisation state and supplies the resume address.

Trap, machine-return and supervisor-return inputs are single-cycle strobes with no back-pressure. Each one commits at the clock edge that ends its strobe cycle. The redirect address is driven combinationally during that strobe cycle. A small configuration port loads the delegation masks, the three vector bases, the two guest-trap control bits and a few seed status bits. Combinational outputs give the environment-call cause code for the current mode. Two more combinational outputs flag that a supervisor return or a wait-for-interrupt would fault as a virtual-instruction exception.

Top module: `trapu_core`

## Requirements
- R1: After reset the mode is machine (code 3), the virtualisation flag is 0, every status bit and capture register is 0, and `redirect_valid` is 0. Mode and virtualisation flag change only on a strobe that takes effect.
- R2: A trap is routed to the guest supervisor when the cause bit is set in both the machine and the hypervisor delegation masks, virtualisation is on and the mode is below machine. Interrupts use the interrupt mask pair and exceptions use the exception mask pair. Otherwise the trap goes to the host supervisor when the machine mask bit is set and the mode is below machine. Otherwise it goes to machine level. A cause number of XLEN or more is never delegated.
- R3: The handler address is the selected level's vector base with bit 0 cleared. When bit 0 of the base is 1 and the trap is an interrupt, four times the cause number is added.
- R4: A guest-supervisor trap keeps virtualisation on and sets the mode to supervisor (1). It stores epc and tval in the guest capture registers. It stores the cause word (interrupt flag in bit XLEN-1, cause number in the low bits), minus one for interrupts, in the guest cause register. It also copies SIE to SPIE, records whether the old mode was supervisor in SPP, and clears SIE.
- R5: A host-supervisor trap clears virtualisation and sets the mode to supervisor. It stores cause, epc and tval in the host registers and tval2 and tinst in the hypervisor registers. It saves the old virtualisation flag to SPV and old-mode-was-supervisor to SPVP, copies the trap's guest-address flag into the hypervisor GVA bit, and updates SPIE/SPP/SIE as in R4.
- R6: A machine trap clears virtualisation and sets the mode to 3. It stores cause, epc, tval, tval2 and tinst in the machine registers, copies MIE to MPIE, saves the old mode to MPP, clears MIE, saves the old virtualisation flag to MPV and copies the guest-address flag to the machine GVA bit.
- R7: A machine return, taken only in machine mode, redirects to the machine epc, sets the mode to MPP, sets virtualisation to MPV unless MPP is machine, copies MPIE to MIE, sets MPIE to 1 and MPP to user (0). In any other mode the strobe has no effect.
- R8: A supervisor return, taken only from supervisor or machine mode, redirects to the guest epc when virtualisation is on and to the host epc otherwise. It sets the mode to supervisor if SPP is 1 and user otherwise, copies SPIE to SIE, sets SPIE to 1 and clears SPP. Only when virtualisation was off does it load virtualisation from SPV.
- R9: `ecall_code` is 8 in user mode, 9 in supervisor mode with virtualisation off, 10 in supervisor mode with virtualisation on, and 11 in machine mode.
- R10: With virtualisation on, `sret_vfault` equals the guest-return trap bit and `wfi_vfault` equals the guest-wait trap bit. While `sret_vfault` is 1 a supervisor return strobe has no effect.
- R11: A trap strobe in the same cycle as a return strobe is handled as the trap alone. The return changes nothing. A machine return takes precedence over a supervisor return.
- R12: Configuration select codes are: 0 exception machine mask, 1 interrupt machine mask, 2 exception hypervisor mask, 3 interrupt hypervisor mask, 4 guest vector, 5 host vector, 6 machine vector, 7 guest controls (bit 0 return trap, bit 1 wait trap), 8 seed status (bit 0 MIE, bit 1 SIE, bits 3:2 MPP with 2 read as user, bit 4 MPV). Vector writes clear bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| trap_valid | input | 1 | Trap strobe |
| trap_irq | input | 1 | Trap is an interrupt |
| trap_cause | input | CW | Cause number |
| trap_epc | input | XLEN | Faulting PC |
| trap_tval | input | XLEN | Trap value |
| trap_tval2 | input | XLEN | Second trap value |
| trap_tinst | input | XLEN | Transformed instruction |
| trap_gva | input | 1 | tval holds a guest virtual address |
| mret_valid | input | 1 | Machine return strobe |
| sret_valid | input | 1 | Supervisor return strobe |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration select |
| cfg_data | input | XLEN | Configuration data |
| redirect_valid | output | 1 | PC redirect this cycle |
| redirect_pc | output | XLEN | Redirect target |
| cur_mode | output | 2 | Mode: 0 user, 1 supervisor, 3 machine |
| cur_virt | output | 1 | Virtualisation flag |
| ecall_code | output | 4 | Environment-call cause for current mode |
| sret_vfault | output | 1 | Supervisor return would fault |
| wfi_vfault | output | 1 | Wait-for-interrupt would fault |
| st_mie | output | 1 | MIE |
| st_mpie | output | 1 | MPIE |
| st_mpp | output | 2 | MPP |
| st_mpv | output | 1 | MPV |
| st_mgva | output | 1 | Machine GVA |
| st_sie | output | 1 | SIE |
| st_spie | output | 1 | SPIE |
| st_spp | output | 1 | SPP |
| st_spv | output | 1 | SPV |
| st_spvp | output | 1 | SPVP |
| st_hgva | output | 1 | Hypervisor GVA |
| m_cause | output | XLEN | Machine cause |
| m_epc | output | XLEN | Machine epc |
| m_tval | output | XLEN | Machine tval |
| m_tval2 | output | XLEN | Machine tval2 |
| m_tinst | output | XLEN | Machine tinst |
| s_cause | output | XLEN | Host cause |
| s_epc | output | XLEN | Host epc |
| s_tval | output | XLEN | Host tval |
| h_tval | output | XLEN | Hypervisor tval2 capture |
| h_tinst | output | XLEN | Hypervisor tinst capture |
| vs_cause | output | XLEN | Guest cause |
| vs_epc | output | XLEN | Guest epc |
| vs_tval | output | XLEN | Guest tval |

## Verification
A trap and a machine return can arrive in the same cycle. The bench provokes this in machine mode by raising both strobes together with a vectored interrupt cause. It then judges the outcome by the redirect address and by MPP and MPIE on the next cycle: the redirect must be the interrupt vector, MPP must hold 3 and MPIE must hold the old MIE, and not the user/1 values a return would write. A blocked supervisor return under the guest-return trap bit is judged in the same way, through SIE and the mode staying put.

// File: rtl/trapu_pkg.sv
package trapu_pkg;
  typedef enum logic [1:0] {
    MODE_USR = 2'd0,
    MODE_SUP = 2'd1,
    MODE_MAC = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    DEST_VS = 2'd0,
    DEST_HS = 2'd1,
    DEST_M  = 2'd2
  } dest_e;

  localparam int NUM_DEST = 3;

  localparam logic [3:0] SEL_EDLG_M = 4'd0;
  localparam logic [3:0] SEL_IDLG_M = 4'd1;
  localparam logic [3:0] SEL_EDLG_H = 4'd2;
  localparam logic [3:0] SEL_IDLG_H = 4'd3;
  localparam logic [3:0] SEL_VEC_VS = 4'd4;
  localparam logic [3:0] SEL_VEC_HS = 4'd5;
  localparam logic [3:0] SEL_VEC_M  = 4'd6;
  localparam logic [3:0] SEL_GCTL   = 4'd7;
  localparam logic [3:0] SEL_STAT   = 4'd8;
endpackage

// File: rtl/trapu_cfg.sv
module trapu_cfg
  import trapu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr,
  input  logic [3:0]                    sel,
  input  logic [XLEN-1:0]               data,
  output logic [XLEN-1:0]               edlg_m,
  output logic [XLEN-1:0]               idlg_m,
  output logic [XLEN-1:0]               edlg_h,
  output logic [XLEN-1:0]               idlg_h,
  output logic [NUM_DEST-1:0][XLEN-1:0] tvec,
  output logic                          gtrap_ret,
  output logic                          gtrap_wait
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edlg_m     <= '0;
      idlg_m     <= '0;
      edlg_h     <= '0;
      idlg_h     <= '0;
      gtrap_ret  <= 1'b0;
      gtrap_wait <= 1'b0;
    end else if (wr) begin
      case (sel)
        SEL_EDLG_M: edlg_m <= data;
        SEL_IDLG_M: idlg_m <= data;
        SEL_EDLG_H: edlg_h <= data;
        SEL_IDLG_H: idlg_h <= data;
        SEL_GCTL: begin
          gtrap_ret  <= data[0];
          gtrap_wait <= data[1];
        end
        default: ;
      endcase
    end
  end

  // One vector base per destination; select code = SEL_VEC_VS + destination index.
  for (genvar g = 0; g < NUM_DEST; g++) begin : g_tvec
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        tvec[g] <= '0;
      else if (wr && sel == SEL_VEC_VS + 4'(g))
        tvec[g] <= data & ~XLEN'(2);
    end
  end
endmodule

// File: rtl/trapu_route.sv
module trapu_route
  import trapu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int CW   = 6
) (
  input  logic [CW-1:0]   cause,
  input  logic            irq,
  input  mode_e           mode,
  input  logic            virt,
  input  logic [XLEN-1:0] edlg_m,
  input  logic [XLEN-1:0] idlg_m,
  input  logic [XLEN-1:0] edlg_h,
  input  logic [XLEN-1:0] idlg_h,
  output dest_e           dest
);
  localparam int IW = $clog2(XLEN);

  logic            in_range;
  logic            below_m;
  logic [IW-1:0]   idx;
  logic [XLEN-1:0] msk_m, msk_h;
  logic            hit_vs, hit_hs;

  always_comb begin
    in_range = int'(cause) < XLEN;
    below_m  = mode != MODE_MAC;
    idx      = cause[IW-1:0];
    msk_m    = irq ? idlg_m : edlg_m;
    msk_h    = irq ? idlg_h : edlg_h;
    hit_vs   = in_range && below_m && virt && msk_m[idx] && msk_h[idx];
    hit_hs   = in_range && below_m && msk_m[idx];
    if (hit_vs)      dest = DEST_VS;
    else if (hit_hs) dest = DEST_HS;
    else             dest = DEST_M;
  end
endmodule

// File: rtl/trapu_vector.sv
module trapu_vector #(
  parameter int XLEN = 32,
  parameter int CW   = 6
) (
  input  logic [XLEN-1:0] base,
  input  logic [CW-1:0]   cause,
  input  logic            irq,
  output logic [XLEN-1:0] pc
);
  logic [XLEN-1:0] offs;

  always_comb begin
    offs = (base[0] && irq) ? ({{(XLEN-CW){1'b0}}, cause} << 2) : '0;
    pc   = {base[XLEN-1:1], 1'b0} + offs;
  end
endmodule

// File: rtl/trapu_core.sv
module trapu_core
  import trapu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int CW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_valid,
  input  logic            trap_irq,
  input  logic [CW-1:0]   trap_cause,
  input  logic [XLEN-1:0] trap_epc,
  input  logic [XLEN-1:0] trap_tval,
  input  logic [XLEN-1:0] trap_tval2,
  input  logic [XLEN-1:0] trap_tinst,
  input  logic            trap_gva,
  input  logic            mret_valid,
  input  logic            sret_valid,
  input  logic            cfg_wr,
  input  logic [3:0]      cfg_sel,
  input  logic [XLEN-1:0] cfg_data,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic [1:0]      cur_mode,
  output logic            cur_virt,
  output logic [3:0]      ecall_code,
  output logic            sret_vfault,
  output logic            wfi_vfault,
  output logic            st_mie,
  output logic            st_mpie,
  output logic [1:0]      st_mpp,
  output logic            st_mpv,
  output logic            st_mgva,
  output logic            st_sie,
  output logic            st_spie,
  output logic            st_spp,
  output logic            st_spv,
  output logic            st_spvp,
  output logic            st_hgva,
  output logic [XLEN-1:0] m_cause,
  output logic [XLEN-1:0] m_epc,
  output logic [XLEN-1:0] m_tval,
  output logic [XLEN-1:0] m_tval2,
  output logic [XLEN-1:0] m_tinst,
  output logic [XLEN-1:0] s_cause,
  output logic [XLEN-1:0] s_epc,
  output logic [XLEN-1:0] s_tval,
  output logic [XLEN-1:0] h_tval,
  output logic [XLEN-1:0] h_tinst,
  output logic [XLEN-1:0] vs_cause,
  output logic [XLEN-1:0] vs_epc,
  output logic [XLEN-1:0] vs_tval
);
  logic [XLEN-1:0]               edlg_m, idlg_m, edlg_h, idlg_h;
  logic [NUM_DEST-1:0][XLEN-1:0] tvec;
  logic [NUM_DEST-1:0][XLEN-1:0] vec_pc;
  logic                          gtrap_ret, gtrap_wait;
  mode_e                         mode;
  logic                          virt;
  dest_e                         dest;
  logic                          mret_go, sret_go;
  logic [XLEN-1:0]               cause_word, cause_guest;
  logic                          from_sup;

  trapu_cfg #(.XLEN(XLEN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel), .data(cfg_data),
    .edlg_m(edlg_m), .idlg_m(idlg_m), .edlg_h(edlg_h), .idlg_h(idlg_h),
    .tvec(tvec), .gtrap_ret(gtrap_ret), .gtrap_wait(gtrap_wait)
  );

  trapu_route #(.XLEN(XLEN), .CW(CW)) u_route (
    .cause(trap_cause), .irq(trap_irq), .mode(mode), .virt(virt),
    .edlg_m(edlg_m), .idlg_m(idlg_m), .edlg_h(edlg_h), .idlg_h(idlg_h),
    .dest(dest)
  );

  for (genvar g = 0; g < NUM_DEST; g++) begin : g_vec
    trapu_vector #(.XLEN(XLEN), .CW(CW)) u_vec (
      .base(tvec[g]), .cause(trap_cause), .irq(trap_irq), .pc(vec_pc[g])
    );
  end

  always_comb begin
    cause_word  = {trap_irq, {(XLEN-1-CW){1'b0}}, trap_cause};
    cause_guest = trap_irq ? cause_word - XLEN'(1) : cause_word;
    from_sup    = mode == MODE_SUP;
    sret_vfault = virt && gtrap_ret;
    wfi_vfault  = virt && gtrap_wait;
    mret_go     = !trap_valid && mret_valid && mode == MODE_MAC;
    sret_go     = !trap_valid && !mret_go && sret_valid &&
                  mode != MODE_USR && !sret_vfault;
    redirect_valid = trap_valid || mret_go || sret_go;
    if (trap_valid)   redirect_pc = vec_pc[dest];
    else if (mret_go) redirect_pc = m_epc;
    else if (virt)    redirect_pc = vs_epc;
    else              redirect_pc = s_epc;
    case (mode)
      MODE_USR: ecall_code = 4'd8;
      MODE_SUP: ecall_code = virt ? 4'd10 : 4'd9;
      default:  ecall_code = 4'd11;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= MODE_MAC;
      virt    <= 1'b0;
      st_mie  <= 1'b0; st_mpie <= 1'b0; st_mpp  <= 2'd0; st_mpv <= 1'b0;
      st_mgva <= 1'b0; st_sie  <= 1'b0; st_spie <= 1'b0; st_spp <= 1'b0;
      st_spv  <= 1'b0; st_spvp <= 1'b0; st_hgva <= 1'b0;
      m_cause <= '0; m_epc <= '0; m_tval <= '0; m_tval2 <= '0; m_tinst <= '0;
      s_cause <= '0; s_epc <= '0; s_tval <= '0; h_tval  <= '0; h_tinst <= '0;
      vs_cause <= '0; vs_epc <= '0; vs_tval <= '0;
    end else begin
      if (cfg_wr && cfg_sel == SEL_STAT) begin
        st_mie <= cfg_data[0];
        st_sie <= cfg_data[1];
        st_mpp <= (cfg_data[3:2] == 2'd2) ? 2'd0 : cfg_data[3:2];
        st_mpv <= cfg_data[4];
      end
      if (trap_valid) begin
        case (dest)
          DEST_VS: begin
            mode     <= MODE_SUP;
            vs_cause <= cause_guest;
            vs_epc   <= trap_epc;
            vs_tval  <= trap_tval;
            st_spie  <= st_sie;
            st_spp   <= from_sup;
            st_sie   <= 1'b0;
          end
          DEST_HS: begin
            mode    <= MODE_SUP;
            virt    <= 1'b0;
            s_cause <= cause_word;
            s_epc   <= trap_epc;
            s_tval  <= trap_tval;
            h_tval  <= trap_tval2;
            h_tinst <= trap_tinst;
            st_spie <= st_sie;
            st_spp  <= from_sup;
            st_sie  <= 1'b0;
            st_spv  <= virt;
            st_spvp <= from_sup;
            st_hgva <= trap_gva;
          end
          default: begin
            mode    <= MODE_MAC;
            virt    <= 1'b0;
            m_cause <= cause_word;
            m_epc   <= trap_epc;
            m_tval  <= trap_tval;
            m_tval2 <= trap_tval2;
            m_tinst <= trap_tinst;
            st_mpie <= st_mie;
            st_mpp  <= mode;
            st_mie  <= 1'b0;
            st_mpv  <= virt;
            st_mgva <= trap_gva;
          end
        endcase
      end else if (mret_go) begin
        mode    <= mode_e'(st_mpp);
        virt    <= (st_mpp != 2'(MODE_MAC)) && st_mpv;
        st_mie  <= st_mpie;
        st_mpie <= 1'b1;
        st_mpp  <= 2'(MODE_USR);
      end else if (sret_go) begin
        mode    <= st_spp ? MODE_SUP : MODE_USR;
        st_sie  <= st_spie;
        st_spie <= 1'b1;
        st_spp  <= 1'b0;
        if (!virt) virt <= st_spv;
      end
    end
  end

  assign cur_mode = mode;
  assign cur_virt = virt;
endmodule

// File: rtl/trapu_core_chk.sv
module trapu_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       trap_valid,
  input logic       mret_valid,
  input logic       sret_valid,
  input logic       redirect_valid,
  input logic [1:0] cur_mode,
  input logic       cur_virt,
  input logic [3:0] ecall_code,
  input logic       sret_vfault,
  input logic [1:0] st_mpp,
  input logic       st_mpie
);
  assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_valid && !mret_valid && !sret_valid) |=> ($stable(cur_mode) && $stable(cur_virt)));

  assert_no_guest_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && !cur_virt) |=> !cur_virt);

  assert_mach_stays_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && cur_mode == 2'd3) |=> (cur_mode == 2'd3 && !cur_virt));

  assert_mret_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mret_valid && !trap_valid && cur_mode == 2'd3) |=> (st_mpp == 2'd0 && st_mpie));

  assert_ecall_after_mtrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && cur_mode == 2'd3) |=> ecall_code == 4'd11);

  assert_sret_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sret_valid && sret_vfault && !trap_valid && !mret_valid) |=>
      ($stable(cur_mode) && $stable(cur_virt)));

  assert_trap_redirects_R11: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> redirect_valid);
endmodule

bind trapu_core trapu_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .mret_valid(mret_valid),
  .sret_valid(sret_valid), .redirect_valid(redirect_valid), .cur_mode(cur_mode),
  .cur_virt(cur_virt), .ecall_code(ecall_code), .sret_vfault(sret_vfault),
  .st_mpp(st_mpp), .st_mpie(st_mpie)
);

// File: tb/trapu_core_test.sv
`timescale 1ns/1ps
module trapu_core_test;
  localparam int XLEN = 32;
  localparam int CW   = 6;

  localparam int F_RV = 0,  F_RPC = 1,  F_MODE = 2,  F_VIRT = 3,  F_EC = 4;
  localparam int F_SRF = 5, F_WFF = 6,  F_MIE = 7,   F_MPIE = 8,  F_MPP = 9;
  localparam int F_MPV = 10, F_MGVA = 11, F_SIE = 12, F_SPIE = 13, F_SPP = 14;
  localparam int F_SPV = 15, F_SPVP = 16, F_HGVA = 17, F_MCAUSE = 18, F_MEPC = 19;
  localparam int F_MTVAL = 20, F_MTVAL2 = 21, F_MTINST = 22, F_SCAUSE = 23;
  localparam int F_SEPC = 24, F_STVAL = 25, F_HTVAL = 26, F_HTINST = 27;
  localparam int F_VSCAUSE = 28, F_VSEPC = 29, F_VSTVAL = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_valid = 0, trap_irq = 0, trap_gva = 0;
  logic [CW-1:0] trap_cause = '0;
  logic [XLEN-1:0] trap_epc = '0, trap_tval = '0, trap_tval2 = '0, trap_tinst = '0;
  logic mret_valid = 0, sret_valid = 0, cfg_wr = 0;
  logic [3:0] cfg_sel = '0;
  logic [XLEN-1:0] cfg_data = '0;

  logic redirect_valid;
  logic [XLEN-1:0] redirect_pc;
  logic [1:0] cur_mode, st_mpp;
  logic cur_virt, sret_vfault, wfi_vfault;
  logic [3:0] ecall_code;
  logic st_mie, st_mpie, st_mpv, st_mgva, st_sie, st_spie, st_spp, st_spv, st_spvp, st_hgva;
  logic [XLEN-1:0] m_cause, m_epc, m_tval, m_tval2, m_tinst, s_cause, s_epc, s_tval;
  logic [XLEN-1:0] h_tval, h_tinst, vs_cause, vs_epc, vs_tval;

  always #4 clk = ~clk;

  trapu_core #(.XLEN(XLEN), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_irq(trap_irq),
    .trap_cause(trap_cause), .trap_epc(trap_epc), .trap_tval(trap_tval),
    .trap_tval2(trap_tval2), .trap_tinst(trap_tinst), .trap_gva(trap_gva),
    .mret_valid(mret_valid), .sret_valid(sret_valid), .cfg_wr(cfg_wr),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .cur_mode(cur_mode), .cur_virt(cur_virt),
    .ecall_code(ecall_code), .sret_vfault(sret_vfault), .wfi_vfault(wfi_vfault),
    .st_mie(st_mie), .st_mpie(st_mpie), .st_mpp(st_mpp), .st_mpv(st_mpv),
    .st_mgva(st_mgva), .st_sie(st_sie), .st_spie(st_spie), .st_spp(st_spp),
    .st_spv(st_spv), .st_spvp(st_spvp), .st_hgva(st_hgva),
    .m_cause(m_cause), .m_epc(m_epc), .m_tval(m_tval), .m_tval2(m_tval2),
    .m_tinst(m_tinst), .s_cause(s_cause), .s_epc(s_epc), .s_tval(s_tval),
    .h_tval(h_tval), .h_tinst(h_tinst), .vs_cause(vs_cause), .vs_epc(vs_epc),
    .vs_tval(vs_tval)
  );

  typedef struct {
    int          cyc;
    int          fld;
    logic [31:0] val;
    string       req;
  } exp_t;

  exp_t q[$];
  int cyc_n = 0;
  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  function automatic logic [31:0] read_fld(int f);
    case (f)
      F_RV:      return 32'(redirect_valid);
      F_RPC:     return redirect_pc;
      F_MODE:    return 32'(cur_mode);
      F_VIRT:    return 32'(cur_virt);
      F_EC:      return 32'(ecall_code);
      F_SRF:     return 32'(sret_vfault);
      F_WFF:     return 32'(wfi_vfault);
      F_MIE:     return 32'(st_mie);
      F_MPIE:    return 32'(st_mpie);
      F_MPP:     return 32'(st_mpp);
      F_MPV:     return 32'(st_mpv);
      F_MGVA:    return 32'(st_mgva);
      F_SIE:     return 32'(st_sie);
      F_SPIE:    return 32'(st_spie);
      F_SPP:     return 32'(st_spp);
      F_SPV:     return 32'(st_spv);
      F_SPVP:    return 32'(st_spvp);
      F_HGVA:    return 32'(st_hgva);
      F_MCAUSE:  return m_cause;
      F_MEPC:    return m_epc;
      F_MTVAL:   return m_tval;
      F_MTVAL2:  return m_tval2;
      F_MTINST:  return m_tinst;
      F_SCAUSE:  return s_cause;
      F_SEPC:    return s_epc;
      F_STVAL:   return s_tval;
      F_HTVAL:   return h_tval;
      F_HTINST:  return h_tinst;
      F_VSCAUSE: return vs_cause;
      F_VSEPC:   return vs_epc;
      F_VSTVAL:  return vs_tval;
      default:   return 32'hDEAD_BEEF;
    endcase
  endfunction

  // Monitor: samples 2 ns before each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #6;
      while (q.size() > 0 && q[0].cyc <= cyc_n) begin
        exp_t e;
        logic [31:0] got;
        e = q.pop_front();
        got = read_fld(e.fld);
        n_checks++;
        if (got !== e.val) begin
          n_fail++;
          $display("FAIL %s field %0d cycle %0d: got %h expected %h", e.req, e.fld, cyc_n, got, e.val);
        end
      end
      cyc_n++;
    end
  end

  task automatic exp_now(int f, logic [31:0] v, string r);
    exp_t e;
    e.cyc = cyc_n; e.fld = f; e.val = v; e.req = r;
    q.push_back(e);
  endtask

  task automatic exp_nxt(int f, logic [31:0] v, string r);
    exp_t e;
    e.cyc = cyc_n + 1; e.fld = f; e.val = v; e.req = r;
    q.push_back(e);
  endtask

  task automatic next_cycle();
    @(posedge clk);
    #2;
    trap_valid = 0; mret_valid = 0; sret_valid = 0; cfg_wr = 0;
  endtask

  task automatic cfg(logic [3:0] s, logic [31:0] d);
    cfg_wr = 1; cfg_sel = s; cfg_data = d;
    next_cycle();
  endtask

  task automatic set_trap(logic irq, logic [CW-1:0] c, logic [31:0] epc,
                          logic [31:0] tv, logic [31:0] tv2, logic [31:0] ti, logic g);
    trap_valid = 1; trap_irq = irq; trap_cause = c; trap_epc = epc;
    trap_tval = tv; trap_tval2 = tv2; trap_tinst = ti; trap_gva = g;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1;
    // R1 reset state
    exp_now(F_MODE, 3, "R1"); exp_now(F_VIRT, 0, "R1"); exp_now(F_MIE, 0, "R1");
    exp_now(F_MPP, 0, "R1"); exp_now(F_RV, 0, "R1"); exp_now(F_MCAUSE, 0, "R1");
    exp_now(F_EC, 11, "R9");
    next_cycle();

    // R12 configuration
    cfg(4'd0, 32'h104);   // exc machine mask: causes 2, 8
    cfg(4'd1, 32'h060);   // irq machine mask: causes 5, 6
    cfg(4'd2, 32'h004);   // exc hyp mask: cause 2
    cfg(4'd3, 32'h040);   // irq hyp mask: cause 6
    cfg(4'd6, 32'h1003);  // machine vector, vectored, bit 1 must drop
    cfg(4'd5, 32'h2000);  // host vector, direct
    cfg(4'd4, 32'h3001);  // guest vector, vectored
    exp_now(F_MODE, 3, "R1");
    cfg(4'd8, 32'h11);    // MIE=1, MPP=U, MPV=1

    // R7 mret into guest user
    mret_valid = 1;
    exp_now(F_RV, 1, "R7"); exp_now(F_RPC, 0, "R7");
    exp_nxt(F_MODE, 0, "R7"); exp_nxt(F_VIRT, 1, "R7"); exp_nxt(F_MIE, 0, "R7");
    exp_nxt(F_MPIE, 1, "R7"); exp_nxt(F_MPP, 0, "R7"); exp_nxt(F_EC, 8, "R9");
    next_cycle();

    // R4 exception from guest user delegated to guest supervisor
    set_trap(0, 6'd2, 32'h400, 32'h55, 32'h0, 32'h0, 0);
    exp_now(F_RPC, 32'h3000, "R3");
    exp_nxt(F_MODE, 1, "R4"); exp_nxt(F_VIRT, 1, "R4"); exp_nxt(F_VSCAUSE, 2, "R4");
    exp_nxt(F_VSEPC, 32'h400, "R4"); exp_nxt(F_VSTVAL, 32'h55, "R4");
    exp_nxt(F_SPP, 0, "R4"); exp_nxt(F_SIE, 0, "R4"); exp_nxt(F_EC, 10, "R9");
    next_cycle();

    // R4 interrupt in guest supervisor: renumber, R3 vectored offset
    set_trap(1, 6'd6, 32'h600, 32'h0, 32'h0, 32'h0, 0);
    exp_now(F_RPC, 32'h3018, "R3");
    exp_nxt(F_VSCAUSE, 32'h8000_0005, "R4"); exp_nxt(F_VSEPC, 32'h600, "R4");
    exp_nxt(F_SPP, 1, "R4"); exp_nxt(F_VIRT, 1, "R2");
    next_cycle();

    // R8 sret with virtualisation on uses guest epc, keeps V
    sret_valid = 1;
    exp_now(F_RV, 1, "R8"); exp_now(F_RPC, 32'h600, "R8");
    exp_nxt(F_MODE, 1, "R8"); exp_nxt(F_VIRT, 1, "R8"); exp_nxt(F_SPP, 0, "R8");
    exp_nxt(F_SPIE, 1, "R8"); exp_nxt(F_SIE, 0, "R8");
    next_cycle();

    // R10 guest-return trap blocks sret
    cfg(4'd7, 32'h1);
    exp_now(F_SRF, 1, "R10"); exp_now(F_WFF, 0, "R10");
    sret_valid = 1;
    exp_now(F_RV, 0, "R10");
    exp_nxt(F_SIE, 0, "R10"); exp_nxt(F_MODE, 1, "R10"); exp_nxt(F_VIRT, 1, "R10");
    next_cycle();
    cfg(4'd7, 32'h2);
    exp_now(F_SRF, 0, "R10"); exp_now(F_WFF, 1, "R10");
    cfg(4'd7, 32'h0);

    // R5 exception from guest supervisor to host supervisor
    set_trap(0, 6'd8, 32'h800, 32'h77, 32'h88, 32'h99, 1);
    exp_now(F_RPC, 32'h2000, "R3");
    exp_nxt(F_MODE, 1, "R5"); exp_nxt(F_VIRT, 0, "R5"); exp_nxt(F_SCAUSE, 8, "R5");
    exp_nxt(F_SEPC, 32'h800, "R5"); exp_nxt(F_STVAL, 32'h77, "R5");
    exp_nxt(F_HTVAL, 32'h88, "R5"); exp_nxt(F_HTINST, 32'h99, "R5");
    exp_nxt(F_SPV, 1, "R5"); exp_nxt(F_SPVP, 1, "R5"); exp_nxt(F_HGVA, 1, "R5");
    exp_nxt(F_SPP, 1, "R5"); exp_nxt(F_EC, 9, "R9");
    next_cycle();

    // R8 sret from host restores V from SPV
    sret_valid = 1;
    exp_now(F_RPC, 32'h800, "R8");
    exp_nxt(F_MODE, 1, "R8"); exp_nxt(F_VIRT, 1, "R8");
    next_cycle();

    // R2 interrupt delegated only at machine mask level goes to host
    set_trap(1, 6'd5, 32'hA00, 32'h0, 32'h0, 32'h0, 0);
    exp_now(F_RPC, 32'h2000, "R3");
    exp_nxt(F_SCAUSE, 32'h8000_0005, "R2"); exp_nxt(F_VIRT, 0, "R2");
    exp_nxt(F_SPV, 1, "R5");
    next_cycle();

    // R6 undelegated exception from host to machine
    cfg(4'd8, 32'h01);
    set_trap(0, 6'd3, 32'hB00, 32'h33, 32'h44, 32'h66, 1);
    exp_now(F_RPC, 32'h1000, "R3");
    exp_nxt(F_MODE, 3, "R6"); exp_nxt(F_VIRT, 0, "R6"); exp_nxt(F_MCAUSE, 3, "R6");
    exp_nxt(F_MEPC, 32'hB00, "R6"); exp_nxt(F_MTVAL, 32'h33, "R6");
    exp_nxt(F_MTVAL2, 32'h44, "R6"); exp_nxt(F_MTINST, 32'h66, "R6");
    exp_nxt(F_MPP, 1, "R6"); exp_nxt(F_MPV, 0, "R6"); exp_nxt(F_MGVA, 1, "R6");
    exp_nxt(F_MPIE, 1, "R6"); exp_nxt(F_MIE, 0, "R6"); exp_nxt(F_EC, 11, "R9");
    next_cycle();

    // R11 trap and mret together: trap wins; R12 vector bit 1 dropped
    set_trap(1, 6'd7, 32'hC00, 32'h0, 32'h0, 32'h0, 0);
    mret_valid = 1;
    exp_now(F_RPC, 32'h101C, "R11");
    exp_nxt(F_MODE, 3, "R11"); exp_nxt(F_MCAUSE, 32'h8000_0007, "R11");
    exp_nxt(F_MEPC, 32'hC00, "R11"); exp_nxt(F_MPP, 3, "R11"); exp_nxt(F_MPIE, 0, "R11");
    next_cycle();

    // R7 mret back to machine
    mret_valid = 1;
    exp_now(F_RPC, 32'hC00, "R7");
    exp_nxt(F_MODE, 3, "R7"); exp_nxt(F_VIRT, 0, "R7"); exp_nxt(F_MPP, 0, "R7");
    exp_nxt(F_MPIE, 1, "R7"); exp_nxt(F_MIE, 0, "R7");
    next_cycle();

    // R7 mret into guest user, then mret from user ignored
    cfg(4'd8, 32'h11);
    mret_valid = 1;
    exp_nxt(F_MODE, 0, "R7"); exp_nxt(F_VIRT, 1, "R7"); exp_nxt(F_MIE, 1, "R7");
    next_cycle();
    mret_valid = 1;
    exp_now(F_RV, 0, "R7");
    exp_nxt(F_MODE, 0, "R7"); exp_nxt(F_VIRT, 1, "R7");
    next_cycle();

    // R2 cause >= XLEN never delegated (low bits alias delegated cause 8)
    set_trap(0, 6'd40, 32'hD00, 32'h0, 32'h0, 32'h0, 0);
    exp_now(F_RPC, 32'h1000, "R2");
    exp_nxt(F_MODE, 3, "R2"); exp_nxt(F_MCAUSE, 32'd40, "R2"); exp_nxt(F_MPV, 1, "R6");
    exp_nxt(F_MPP, 0, "R6"); exp_nxt(F_MPIE, 1, "R6"); exp_nxt(F_VIRT, 0, "R6");
    next_cycle();

    // R1 no strobe: nothing moves
    exp_nxt(F_MODE, 3, "R1"); exp_nxt(F_RV, 0, "R1");
    next_cycle();
    repeat (3) next_cycle();
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R1 scoreboard: got %0d pending expected 0", q.size());
    end
    finished = 1;
    summary();
  end
endmodule